// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the single memory reservation that one 32-bit core needs for atomic read-modify-write sequences. A load-reserve access opens a reservation on the word it reads. Until the matching store-conditional arrives, the block watches every ordinary store the core issues, and any store that lands on the reserved word cancels the reservation.

When the store-conditional arrives, the block decides whether it succeeds. It returns that decision as the new value of the core's condition flag, and it gates the memory write of the conditional store on it. Every store-conditional consumes the reservation, whether it passes or fails. Address generation, the memory itself, coherence with other cores and exception handling all stay outside the block.

Decisions are registered. The flag update and the gated write request appear on the outputs one clock after the store-conditional is presented.

Top module: `lrsc_monitor`

## Requirements
- R1: A synchronous active-high reset drops any reservation and clears the recorded address. While reset is held and in the first cycle after it, `flag_we` and `mem_we` are 0, so a store-conditional right after reset fails, even to address 0.
- R2: A load-reserve (`lr_valid`=1) opens a reservation and records the full 32-bit `lr_addr`.
- R3: A store-conditional (`sc_valid`=1) in cycle N gives `flag_we`=1 in cycle N+1. In that cycle `flag` is 1 only if a reservation is open and `sc_addr` equals the recorded address exactly. Otherwise `flag` is 0. `flag_we` is 0 in every cycle that does not follow a store-conditional.
- R4: `mem_we` is 1 in cycle N+1 only for a store-conditional that succeeded. In that cycle `mem_addr` and `mem_wdata` carry that request's `sc_addr` and `sc_wdata`.
- R5: Every store-conditional ends the reservation, whether it passes or fails, so a second one without a new load-reserve fails.
- R6: An ordinary store (`st_valid`=1, any access size) ends an open reservation when (`st_addr` & 0x0FFFFFFC) equals the recorded address. As a consequence, a recorded address with any of bits 31..28 set, or with bit 0 or 1 set, is never cleared by a store.
- R7: An ordinary store whose masked address differs from the recorded address leaves the reservation intact. No ordinary store ever opens a reservation, and none ever drives `flag_we` or `mem_we`.
- R8: When a load-reserve and a store that would clear the reservation are presented in the same cycle, the load-reserve wins and the reservation is open afterwards.
- R9: A store-conditional whose address has bit 1 or bit 0 set fails (`flag`=0, `mem_we`=0), even if it equals the recorded address.
- R10: A second load-reserve replaces the recorded address, so a store-conditional to the earlier address then fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_valid | input | 1 | Load-reserve access this cycle |
| lr_addr | input | 32 | Effective address of the load-reserve |
| sc_valid | input | 1 | Store-conditional request this cycle |
| sc_addr | input | 32 | Effective address of the store-conditional |
| sc_wdata | input | 32 | Source register value of the store-conditional |
| st_valid | input | 1 | Ordinary byte, halfword or word store this cycle |
| st_addr | input | 32 | Effective address of the ordinary store |
| flag_we | output | 1 | Condition-flag update strobe |
| flag | output | 1 | New condition-flag value (1 = store-conditional succeeded) |
| mem_we | output | 1 | Gated write enable for the conditional store |
| mem_addr | output | 32 | Write address of the conditional store |
| mem_wdata | output | 32 | Write data of the conditional store |

## Verification
The sweep opens reservations on several base addresses. Some lie in the low region, some at the top of the masked range, and some have the upper nibble set. For each base it issues ordinary stores at every byte offset from -8 to +11. This separates the masked word compare from an exact compare and from a compare that ignores the upper bits. A second sweep sends store-conditionals to the same offsets. That shows the exact compare and the misalignment rejection, including a reservation opened on a misaligned address. Directed sequences cover the remaining cases: back-to-back store-conditionals, a load-reserve that replaces an earlier one, a load-reserve paired with a clearing store, and stores with no reservation open. They tell apart the priority rule, the rule that every store-conditional consumes the reservation, and the rule that stores never open one.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  // Default widths for the monitor
  localparam int unsigned LRSC_AW = 32;
  localparam int unsigned LRSC_DW = 32;

  // Mask applied to ordinary store addresses before the word compare
  localparam logic [LRSC_AW-1:0] LRSC_ST_MASK = 32'h0FFF_FFFC;

  // Next-cycle action on the reservation register
  typedef enum logic [1:0] {
    RSV_KEEP = 2'd0,
    RSV_OPEN = 2'd1,
    RSV_DROP = 2'd2
  } rsv_act_e;

endpackage

// File: rtl/lrsc_addr_match.sv
module lrsc_addr_match #(
  parameter int unsigned    AW     = 32,
  parameter bit             MASKED = 1'b0,
  parameter logic [AW-1:0]  MASK   = '1
) (
  input  logic [AW-1:0] probe,
  input  logic [AW-1:0] held_addr,
  output logic          hit
);

  logic [AW-1:0] probe_eff;

  generate
    if (MASKED) begin : g_masked
      assign probe_eff = probe & MASK;
    end else begin : g_exact
      assign probe_eff = probe;
    end
  endgenerate

  assign hit = (probe_eff == held_addr);

endmodule

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg
  import lrsc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  rsv_act_e      act,
  input  logic [AW-1:0] open_addr,
  output logic          held,
  output logic [AW-1:0] held_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= 1'b0;
      held_addr <= '0;
    end else begin
      case (act)
        RSV_OPEN: begin
          held      <= 1'b1;
          held_addr <= open_addr;
        end
        RSV_DROP: held <= 1'b0;
        default:  ;
      endcase
    end
  end

  // R2
  open_records_chk: assert property (@(posedge clk) disable iff (rst)
    (act == RSV_OPEN) |=> (held && held_addr == $past(open_addr)));

  // R5
  drop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (act == RSV_DROP) |=> !held);

  // R7
  keep_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (act == RSV_KEEP) |=> ($stable(held) && $stable(held_addr)));

endmodule

// File: rtl/lrsc_sc_resp.sv
module lrsc_sc_resp #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sc_req,
  input  logic          sc_pass,
  input  logic [AW-1:0] sc_addr,
  input  logic [DW-1:0] sc_wdata,
  output logic          flag_we,
  output logic          flag,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  localparam int unsigned LANE_BITS = (DW / 8 > 1) ? $clog2(DW / 8) : 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_we   <= 1'b0;
      flag      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      flag_we <= sc_req;
      flag    <= sc_req & sc_pass;
      mem_we  <= sc_req & sc_pass;
      if (sc_req & sc_pass) begin
        mem_addr  <= sc_addr;
        mem_wdata <= sc_wdata;
      end
    end
  end

  // R4
  we_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (flag_we && flag));

  // R9
  we_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[LANE_BITS-1:0] == '0));

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int unsigned   AW      = LRSC_AW,
  parameter int unsigned   DW      = LRSC_DW,
  parameter logic [AW-1:0] ST_MASK = LRSC_ST_MASK
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lr_valid,
  input  logic [AW-1:0] lr_addr,
  input  logic          sc_valid,
  input  logic [AW-1:0] sc_addr,
  input  logic [DW-1:0] sc_wdata,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  output logic          flag_we,
  output logic          flag,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  localparam int unsigned LANE_BITS = (DW / 8 > 1) ? $clog2(DW / 8) : 1;

  logic          held;
  logic [AW-1:0] held_addr;
  logic          sc_hit;
  logic          st_hit;
  logic          sc_misalign;
  logic          sc_pass;
  rsv_act_e      act;

  lrsc_addr_match #(.AW(AW), .MASKED(1'b0), .MASK('1)) u_sc_cmp (
    .probe     (sc_addr),
    .held_addr (held_addr),
    .hit       (sc_hit)
  );

  lrsc_addr_match #(.AW(AW), .MASKED(1'b1), .MASK(ST_MASK)) u_st_cmp (
    .probe     (st_addr),
    .held_addr (held_addr),
    .hit       (st_hit)
  );

  assign sc_misalign = |sc_addr[LANE_BITS-1:0];
  assign sc_pass     = held & sc_hit & ~sc_misalign;

  // Load-reserve has priority over any clearing event in the same cycle
  always_comb begin
    if (lr_valid)                           act = RSV_OPEN;
    else if (sc_valid || (st_valid && st_hit)) act = RSV_DROP;
    else                                    act = RSV_KEEP;
  end

  lrsc_resv_reg #(.AW(AW)) u_resv (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .open_addr (lr_addr),
    .held      (held),
    .held_addr (held_addr)
  );

  lrsc_sc_resp #(.AW(AW), .DW(DW)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .sc_req    (sc_valid),
    .sc_pass   (sc_pass),
    .sc_addr   (sc_addr),
    .sc_wdata  (sc_wdata),
    .flag_we   (flag_we),
    .flag      (flag),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // R3
  sc_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    sc_valid |=> flag_we);

  // R7
  st_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !sc_valid |=> (!flag_we && !mem_we));

  // R8
  lr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (lr_valid && st_valid) |=> held);

  // R9
  misalign_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && sc_misalign) |=> (flag_we && !flag && !mem_we));

endmodule

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;

  localparam logic [31:0] MASK = 32'h0FFF_FFFC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lr_valid = 1'b0;
  logic [31:0] lr_addr = '0;
  logic        sc_valid = 1'b0;
  logic [31:0] sc_addr = '0;
  logic [31:0] sc_wdata = '0;
  logic        st_valid = 1'b0;
  logic [31:0] st_addr = '0;
  logic        flag_we, flag, mem_we;
  logic [31:0] mem_addr, mem_wdata;

  int checks = 0;
  int errors = 0;

  // Bench-side reservation model
  logic        m_held = 1'b0;
  logic [31:0] m_addr = '0;

  always #4 clk = ~clk;

  lrsc_monitor dut (
    .clk(clk), .rst(rst),
    .lr_valid(lr_valid), .lr_addr(lr_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_wdata(sc_wdata),
    .st_valid(st_valid), .st_addr(st_addr),
    .flag_we(flag_we), .flag(flag), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at next falling edge
  task automatic step(input logic lr, input logic [31:0] la,
                      input logic sc, input logic [31:0] sa, input logic [31:0] sd,
                      input logic st, input logic [31:0] sta, input string tag);
    logic exp_pass;
    exp_pass = sc && m_held && (sa == m_addr) && (sa[1:0] == 2'b00);
    lr_valid = lr; lr_addr = la;
    sc_valid = sc; sc_addr = sa; sc_wdata = sd;
    st_valid = st; st_addr = sta;
    @(negedge clk);
    chk(flag_we == sc, {tag, " flag_we"}, {31'd0, flag_we}, {31'd0, sc});
    chk(flag == exp_pass, {tag, " flag"}, {31'd0, flag}, {31'd0, exp_pass});
    chk(mem_we == exp_pass, {tag, " mem_we"}, {31'd0, mem_we}, {31'd0, exp_pass});
    if (exp_pass) begin
      chk(mem_addr == sa, {tag, " mem_addr"}, mem_addr, sa);
      chk(mem_wdata == sd, {tag, " mem_wdata"}, mem_wdata, sd);
    end
    if (sc || (st && m_held && ((sta & MASK) == m_addr))) m_held = 1'b0;
    if (lr) begin m_held = 1'b1; m_addr = la; end
    lr_valid = 1'b0; sc_valid = 1'b0; st_valid = 1'b0;
  endtask

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] bases [6];
    bases[0] = 32'h0000_1000; bases[1] = 32'h0ABC_DEF0; bases[2] = 32'hF000_2000;
    bases[3] = 32'h0000_0000; bases[4] = 32'h0FFF_FFFC; bases[5] = 32'h0000_3002;

    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    chk(!flag_we && !mem_we && !flag, "R1 reset outputs", {29'd0, flag_we, flag, mem_we}, 32'd0);
    rst = 1'b0;
    // R1: store-conditional to address 0 right after reset fails
    step(0, 0, 1, 32'h0, 32'h1111_1111, 0, 0, "R1 sc after reset");

    // R2 R3 R4: basic pass
    step(1, 32'h0000_4000, 0, 0, 0, 0, 0, "R2 open");
    step(0, 0, 1, 32'h0000_4000, 32'hCAFE_F00D, 0, 0, "R3 R4 pass");
    // R5: second sc fails
    step(0, 0, 1, 32'h0000_4000, 32'h1234_5678, 0, 0, "R5 consumed");
    // R5: failing sc also consumes
    step(1, 32'h0000_5000, 0, 0, 0, 0, 0, "R5 open");
    step(0, 0, 1, 32'h0000_5004, 32'h1, 0, 0, "R5 miss sc");
    step(0, 0, 1, 32'h0000_5000, 32'h2, 0, 0, "R5 after miss");
    // R7: stores never open a reservation
    step(0, 0, 0, 0, 0, 1, 32'h0000_6000, "R7 store alone");
    step(0, 0, 1, 32'h0000_6000, 32'h3, 0, 0, "R7 no open by store");
    // R8: lr wins over clearing store in same cycle
    step(1, 32'h0000_7000, 0, 0, 0, 0, 0, "R8 open");
    step(1, 32'h0000_7000, 0, 0, 0, 1, 32'h0000_7000, "R8 lr+store");
    step(0, 0, 1, 32'h0000_7000, 32'h4, 0, 0, "R8 sc");
    // R10: replacement
    step(1, 32'h0000_8000, 0, 0, 0, 0, 0, "R10 first");
    step(1, 32'h0000_9000, 0, 0, 0, 0, 0, "R10 second");
    step(0, 0, 1, 32'h0000_8000, 32'h5, 0, 0, "R10 old addr");
    step(1, 32'h0000_9000, 0, 0, 0, 0, 0, "R10 reopen");
    step(0, 0, 1, 32'h0000_9000, 32'h6, 0, 0, "R10 new addr");

    // R6 R7: store sweep over byte offsets around each base
    foreach (bases[b]) begin
      for (int off = -8; off <= 11; off++) begin
        step(1, bases[b], 0, 0, 0, 0, 0, "R2 sweep open");
        step(0, 0, 0, 0, 0, 1, bases[b] + off, "R6 R7 sweep store");
        step(0, 0, 1, bases[b], bases[b] ^ 32'h5A5A_5A5A, 0, 0, "R6 R7 sweep sc");
      end
    end

    // R3 R9: store-conditional sweep over byte offsets
    foreach (bases[b]) begin
      for (int off = -8; off <= 11; off++) begin
        step(1, bases[b], 0, 0, 0, 0, 0, "R2 sc sweep open");
        step(0, 0, 1, bases[b] + off, 32'hA5A5_0000 + off, 0, 0, "R3 R9 sc sweep");
      end
    end

    // R6: store with the top nibble differing still clears a low reservation
    step(1, 32'h0000_1000, 0, 0, 0, 0, 0, "R6 open");
    step(0, 0, 0, 0, 0, 1, 32'hF000_1000, "R6 high alias store");
    step(0, 0, 1, 32'h0000_1000, 32'h7, 0, 0, "R6 alias cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule